// File: doc/BRIEF.md
# Split-Phase Receive Byte Clock Generator

This block runs on the recovered bit clock and produces a pair of receive byte clocks. Each byte clock runs at half the word rate, and the two are in antiphase. Consecutive received words are presented on alternate rising edges, first one clock and then the other. A selector output shows which of the two clocks launched the word currently on the bus.

A comma detector upstream raises `realign` for one bit clock when it finds a new word boundary. The generator then moves its clocks to the new grid. It never ends a phase early. Instead it lengthens the high or low phase in progress by whole bit clocks until the new grid is reached. After that, normal toggling resumes. The rising edges of the first clock, `bclk_a`, land on even word positions counted from the comma. A second comma that arrives two words later is therefore launched by `bclk_a`.

A word holds `WORD_BITS` bit clocks. Each byte clock is high for `WORD_BITS` bit clocks and low for `WORD_BITS` bit clocks.

In this document, W stands for `WORD_BITS`. Edges are counted as rising edges of `bit_clk` with `rst` low, starting at 1 for the first such edge. "Realign at edge E" means `realign` is sampled high at edge E.

Top module: `rbcg_split_gen`

## Requirements
- R1: While `rst` is high (synchronous, active high), `bclk_a` is 0, `bclk_b` is 1 and `launch_sel` is 1.
- R2: After reset is released, the first change of either clock is `bclk_a` rising at edge W.
- R3: Before any realign, `bclk_b` is always the inverse of `bclk_a`, and `bclk_a` changes only at edges that are multiples of W. This gives each clock W bit clocks high, W low, and a period of 2W.
- R4: `launch_sel` is 0 while `bclk_a` is high (`bclk_a` launched the current word) and 1 while `bclk_b` is high.
- R5: A realign at edge E while `bclk_a` is high, including its final bit clock, keeps `bclk_a` high after E. `bclk_a` then falls at E+W.
- R6: A realign at edge E while `bclk_b` is high, and E is not the edge where `bclk_b` would fall, keeps `bclk_b` high after E until edge E+2W.
- R7: A realign at the edge where `bclk_b` would fall anyway lets the normal toggle happen, so `bclk_a` rises at that edge.
- R8: No high or low phase of `bclk_a` lasts fewer than W bit clocks, whatever the realign pattern, including back-to-back or continuous requests.
- R9: After the last realign at edge L, `bclk_a` changes only at L+kW with k ≥ 1, and rises only at L+2kW with k ≥ 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Recovered bit clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| realign | input | 1 | One-cycle request from comma detection to move to a new word grid |
| bclk_a | output | 1 | First byte clock; its rising edges carry the comma alignment |
| bclk_b | output | 1 | Second byte clock, in antiphase to `bclk_a` |
| launch_sel | output | 1 | 0 when `bclk_a` launched the current word, 1 when `bclk_b` did |

## Verification
The hard case is a realign request that lands on the same edge where the running phase would end anyway. Here the stretch logic and the normal toggle compete for the same cycle. The bench sweeps a single request across every one of the 2W offsets of a steady period, which covers the last bit clock of both the `bclk_a` high phase and the `bclk_b` high phase. Pairs of requests and a continuous burst add the case where a new request arrives while a stretch is still in progress. Each run is judged from the port edges alone: every phase must last at least W bit clocks, the level right after the request must match the stretch rule, and the rises of `bclk_a` must fall on 2W multiples counted from the last request.

// File: rtl/rbcg_pkg.sv
package rbcg_pkg;

   // Action taken by the phase timer on the next bit clock edge
   typedef enum logic [1:0] {
      ACT_COUNT    = 2'd0,  // keep level, count down
      ACT_TOGGLE   = 2'd1,  // swap clocks, start a normal phase
      ACT_HOLD_ONE = 2'd2,  // keep level for one more half period
      ACT_HOLD_TWO = 2'd3   // keep level for two more half periods
   } rbcg_act_e;

endpackage

// File: rtl/rbcg_decide.sv
module rbcg_decide
   import rbcg_pkg::*;
(
   input  logic      realign_i,
   input  logic      phase_b_i,  // 1 while the second clock is high
   input  logic      last_i,     // current phase ends at the next edge
   output rbcg_act_e act_o
);

   // A realign never shortens a phase: first clock high -> stretch by one
   // half period; second clock high -> stretch by two so the first clock
   // rises 2W after the request; at the second clock's own boundary the
   // normal toggle already gives that alignment.
   always_comb begin
      if (!realign_i) begin
         act_o = last_i ? ACT_TOGGLE : ACT_COUNT;
      end else if (!phase_b_i) begin
         act_o = ACT_HOLD_ONE;
      end else if (last_i) begin
         act_o = ACT_TOGGLE;
      end else begin
         act_o = ACT_HOLD_TWO;
      end
   end

endmodule

// File: rtl/rbcg_timer.sv
module rbcg_timer
   import rbcg_pkg::*;
#(
   parameter int HALF = 10
)(
   input  logic      clk_i,
   input  logic      rst_i,
   input  rbcg_act_e act_i,
   output logic      phase_q_o,
   output logic      phase_d_o,
   output logic      last_o
);

   localparam int CW = $clog2(2 * HALF);

   logic [CW-1:0] rem_q, rem_d;
   logic          phase_q, phase_d;

   always_comb begin
      rem_d   = rem_q;
      phase_d = phase_q;
      case (act_i)
         ACT_COUNT:    rem_d = rem_q - CW'(1);
         ACT_TOGGLE: begin
            rem_d   = CW'(HALF - 1);
            phase_d = ~phase_q;
         end
         ACT_HOLD_ONE: rem_d = CW'(HALF - 1);
         ACT_HOLD_TWO: rem_d = CW'(2 * HALF - 1);
         default:      rem_d = rem_q;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         rem_q   <= CW'(HALF - 1);
         phase_q <= 1'b1;
      end else begin
         rem_q   <= rem_d;
         phase_q <= phase_d;
      end
   end

   assign phase_q_o = phase_q;
   assign phase_d_o = phase_d;
   assign last_o    = (rem_q == '0);

endmodule

// File: rtl/rbcg_split_gen.sv
module rbcg_split_gen
   import rbcg_pkg::*;
#(
   parameter int WORD_BITS   = 10,
   parameter bit SPLIT_FLOPS = 1'b1
)(
   input  logic bit_clk,
   input  logic rst,
   input  logic realign,
   output logic bclk_a,
   output logic bclk_b,
   output logic launch_sel
);

   localparam int RUN_MAX = 4 * WORD_BITS;
   localparam int RUNW    = $clog2(RUN_MAX + 1);

   if (WORD_BITS < 2) begin : g_bad_cfg
      $error("rbcg_split_gen: WORD_BITS must be at least 2");
   end

   rbcg_act_e act;
   logic      phase_q, phase_d, last;

   rbcg_decide u_decide (
      .realign_i (realign),
      .phase_b_i (phase_q),
      .last_i    (last),
      .act_o     (act)
   );

   rbcg_timer #(.HALF(WORD_BITS)) u_timer (
      .clk_i     (bit_clk),
      .rst_i     (rst),
      .act_i     (act),
      .phase_q_o (phase_q),
      .phase_d_o (phase_d),
      .last_o    (last)
   );

   assign launch_sel = phase_q;

   if (SPLIT_FLOPS) begin : g_split
      // each clock from its own flop, loaded with the same next phase
      logic a_q, b_q;
      always_ff @(posedge bit_clk) begin
         if (rst) begin
            a_q <= 1'b0;
            b_q <= 1'b1;
         end else begin
            a_q <= ~phase_d;
            b_q <= phase_d;
         end
      end
      assign bclk_a = a_q;
      assign bclk_b = b_q;

      AST_ANTIPHASE: assert property (@(posedge bit_clk) disable iff (rst) bclk_a != bclk_b); // R3
   end else begin : g_shared
      assign bclk_a = ~phase_q;
      assign bclk_b = phase_q;
   end

   // phase length monitor for the no-sliver rule
   logic            a_dly;
   logic [RUNW-1:0] run_len;
   logic            a_moved;

   assign a_moved = (bclk_a != a_dly);

   always_ff @(posedge bit_clk) begin
      if (rst) begin
         a_dly   <= 1'b0;
         run_len <= RUNW'(WORD_BITS);
      end else begin
         a_dly <= bclk_a;
         if (a_moved)
            run_len <= RUNW'(1);
         else if (run_len != RUNW'(RUN_MAX))
            run_len <= run_len + RUNW'(1);
      end
   end

   AST_MIN_PHASE: assert property (@(posedge bit_clk) disable iff (rst) a_moved |-> run_len >= RUNW'(WORD_BITS)); // R8
   AST_HOLD_A: assert property (@(posedge bit_clk) disable iff (rst) (realign && bclk_a) |=> bclk_a); // R5
   AST_HOLD_B: assert property (@(posedge bit_clk) disable iff (rst) (realign && bclk_b && !last) |=> bclk_b); // R6
   AST_EDGE_TOGGLE: assert property (@(posedge bit_clk) disable iff (rst) (realign && bclk_b && last) |=> bclk_a); // R7

endmodule

// File: tb/rbcg_split_gen_tb_top.sv
module rbcg_split_gen_tb_top;

   localparam int W = 10;
   localparam int B = 3 * W;  // steady rising edge of bclk_a used as base

   logic bit_clk = 1'b0;
   logic rst     = 1'b1;
   logic realign = 1'b0;
   logic bclk_a, bclk_b, launch_sel;

   int errors = 0;
   int checks = 0;

   always #5 bit_clk = ~bit_clk;

   rbcg_split_gen #(.WORD_BITS(W), .SPLIT_FLOPS(1'b1)) dut_i (
      .bit_clk    (bit_clk),
      .rst        (rst),
      .realign    (realign),
      .bclk_a     (bclk_a),
      .bclk_b     (bclk_b),
      .launch_sel (launch_sel)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // realign pulses at B+d1 and B+d2; fill asserts it on every edge between
   task automatic run_case(input int d1, input int d2, input bit fill);
      int  last_chg;
      int  rises_after;
      int  lst;
      int  horizon;
      bit  pa;
      string tag;
      lst     = B + d2;
      horizon = lst + 6 * W;
      rst     = 1'b1;
      realign = 1'b0;
      repeat (3) @(negedge bit_clk);
      check(bclk_a == 1'b0, "R1", "bclk_a in reset", int'(bclk_a), 0);
      check(bclk_b == 1'b1, "R1", "bclk_b in reset", int'(bclk_b), 1);
      check(launch_sel == 1'b1, "R1", "launch_sel in reset", int'(launch_sel), 1);
      rst         = 1'b0;
      pa          = 1'b0;
      last_chg    = 0;
      rises_after = 0;
      for (int n = 1; n <= horizon; n++) begin
         realign = (n == B + d1) || (n == B + d2) || (fill && n > B + d1 && n < B + d2);
         @(negedge bit_clk);  // edge n has happened
         check(bclk_b == !bclk_a, "R3", "antiphase", int'(bclk_b), int'(!bclk_a));
         check(launch_sel == bclk_b, "R4", "launch_sel", int'(launch_sel), int'(bclk_b));
         if (d1 == d2 && n == B + d1) begin
            tag = (d1 == 0) ? "R7" : ((d1 <= W) ? "R5" : "R6");
            check(bclk_a == (d1 <= W), tag, "level after realign", int'(bclk_a), int'(d1 <= W));
         end
         if (bclk_a != pa) begin
            check(n - last_chg >= W, "R8", "phase length", n - last_chg, W);
            if (n <= B + d1) begin
               if (last_chg == 0)
                  check(n == W, "R2", "first rise edge", n, W);
               check(n % W == 0, "R3", "steady change edge", n, (n / W) * W);
            end else if (n > lst) begin
               check((n - lst) % W == 0 && n >= lst + W, "R9", "change offset from realign", n - lst, W);
               if (bclk_a) begin
                  check((n - lst) % (2 * W) == 0 && n >= lst + 2 * W, "R9",
                        "rise offset from realign", n - lst, 2 * W);
                  rises_after++;
               end
            end
            pa       = bclk_a;
            last_chg = n;
         end
      end
      realign = 1'b0;
      check(rises_after == 3, "R9", "rises after realign", rises_after, 3);
   endtask

   initial begin
      // single request swept over every offset of one period (R5, R6, R7)
      for (int d = 0; d < 2 * W; d++) run_case(d, d, 1'b0);
      // two requests while bclk_a is high (R5, R8)
      run_case(1, 5, 1'b0);
      // request at bclk_a boundary then again one edge before its new end (R5, R8)
      run_case(W, 2 * W - 1, 1'b0);
      // second request while a stretch of bclk_b is running (R6, R8)
      run_case(W + 2, 3 * W, 1'b0);
      // continuous request over several edges (R8, R9)
      run_case(1, 7, 1'b1);
      run_case(W + 1, 2 * W + 3, 1'b1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(200000 * 10);
      errors++;
      checks++;
      $display("FAIL R1 watchdog expired: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule